// File: doc/BRIEF.md
# Output-Stationary Convolution Array

This block computes a one-dimensional convolution on a row of eight processing elements. Each element keeps one output accumulator for the whole job, so no partial sum is written out and read back. Every step sends one filter weight to all elements at once and performs one multiply-accumulate in each. The input activations sit in a shift chain that moves one position toward element 0 after every step, so each activation enters the block exactly once.

A job starts with `start` and a tap count. The first eight accepted input beats preload the chain, with element i ending up holding x[i]. Each later beat carries the weight for step k together with activation x[8+k], which enters at the top element. After the last tap, element i holds the sum over k of w[k]*x[i+k]. A one-cycle `done` strobe marks completion. The eight sums are available in parallel on `res_flat`, and a serial drain presents them one per cycle.

Top module: `osa_array`

## Requirements
- R1: After reset, `busy`, `done` and `rd_valid` are 0 and every accumulator on `res_flat` is 0.
- R2: A `start` while idle with `taps` between 1 and 64 clears all accumulators and raises `busy` in the next cycle.
- R3: The first eight input beats after an accepted start preload the chain, with the first beat going to element 0 and the eighth to element 7.
- R4: Each compute beat applies `in_wt` to every element and then shifts the chain, with `in_act` entering at element 7. Element i finishes with sum over k of w[k]*x[i+k]. Element i occupies bits [20i+19:20i] of `res_flat`.
- R5: Cycles with `in_valid` low change neither the chain nor the sums, whatever `in_wt` and `in_act` carry.
- R6: `done` is high for exactly one cycle. That cycle directly follows the edge that took the last tap, and `res_flat` holds the final sums during it.
- R7: Weights and activations are signed 8-bit two's complement. Accumulators are signed 20-bit and wrap modulo 2^20.
- R8: A `start` while `busy` is high is ignored, and the running job completes with its original tap count.
- R9: A `start` with `taps` equal to 0 is ignored: `busy` stays low and the sums are unchanged.
- R10: Starting with the `done` cycle, `rd_valid` is high for eight consecutive cycles. During these cycles `rd_idx` counts 0 to 7 and `rd_data` carries the sum of element `rd_idx`. `busy` stays high through the drain.
- R11: While idle, the sums hold their values and `in_valid` beats are ignored.
- R12: A new accepted job starts from zero sums and is not affected by the previous job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job when idle |
| taps | input | 7 | Number of filter taps for the job (1..64) |
| in_valid | input | 1 | Input beat present |
| in_wt | input | 8 | Signed weight for the current step |
| in_act | input | 8 | Signed activation entering the chain |
| busy | output | 1 | Job in progress (load, compute or drain) |
| done | output | 1 | One-cycle completion strobe |
| res_flat | output | 160 | All eight accumulators, element 0 in the low bits |
| rd_valid | output | 1 | Serial readout beat valid |
| rd_idx | output | 3 | Element index of the serial beat |
| rd_data | output | 20 | Accumulator of element `rd_idx` |

## Verification
The properties assume that `taps` stays within 1 to 64 whenever `start` is raised while idle. They also assume that a completed job gets no new accepted start before its drain ends. The stimulus drives only tap counts from 1 to the maximum. It waits for `busy` to fall before each new job. All inputs change one time unit after a rising edge, so no sampled value is ambiguous. Stray `start` pulses during a job are sent with a different tap count, so that a design which wrongly accepts them produces visibly wrong sums.

// File: rtl/osa_pkg.sv
package osa_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_RUN   = 2'd2,
      ST_DRAIN = 2'd3
   } osa_state_e;
endpackage

// File: rtl/osa_pe.sv
// One element: holds an activation slot in the shift chain and a local accumulator.
module osa_pe #(
   parameter int DATA_W = 8,
   parameter int ACC_W  = 20
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     shift,
   input  logic                     mac_en,
   input  logic signed [DATA_W-1:0] wt,
   input  logic signed [DATA_W-1:0] act_in,
   output logic signed [DATA_W-1:0] act_q,
   output logic signed [ACC_W-1:0]  acc_q
);
   localparam int PROD_W = 2 * DATA_W;

   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W-1:0]  prod_ext;

   always_comb begin
      prod     = wt * act_q;
      prod_ext = ACC_W'(prod);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         act_q <= '0;
      end else begin
         if (clr)
            acc_q <= '0;
         else if (mac_en)
            acc_q <= acc_q + prod_ext;
         if (shift)
            act_q <= act_in;
      end
   end
endmodule

// File: rtl/osa_ctrl.sv
// Sequencer: preload count, tap count, done strobe and drain index.
module osa_ctrl
   import osa_pkg::*;
#(
   parameter int N_PE      = 8,
   parameter int MAX_TAPS  = 64,
   parameter bit HAS_DRAIN = 1'b1,
   localparam int TAP_W    = $clog2(MAX_TAPS + 1),
   localparam int IDX_W    = $clog2(N_PE)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [TAP_W-1:0] taps,
   input  logic             in_valid,
   output logic             busy,
   output logic             clr,
   output logic             shift,
   output logic             mac_en,
   output logic             done,
   output logic             drain_valid,
   output logic [IDX_W-1:0] drain_idx
);
   osa_state_e       state;
   logic [IDX_W-1:0] load_cnt;
   logic [TAP_W-1:0] tap_cnt;
   logic [TAP_W-1:0] taps_q;
   logic             accept;
   logic             last_tap;

   always_comb begin
      accept      = (state == ST_IDLE) && start && (taps != '0);
      clr         = accept;
      shift       = in_valid && ((state == ST_LOAD) || (state == ST_RUN));
      mac_en      = in_valid && (state == ST_RUN);
      last_tap    = (tap_cnt == taps_q - TAP_W'(1));
      busy        = (state != ST_IDLE);
      drain_valid = (state == ST_DRAIN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         load_cnt  <= '0;
         tap_cnt   <= '0;
         taps_q    <= '0;
         drain_idx <= '0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  state    <= ST_LOAD;
                  taps_q   <= taps;
                  load_cnt <= '0;
                  tap_cnt  <= '0;
               end
            end
            ST_LOAD: begin
               if (in_valid) begin
                  if (load_cnt == IDX_W'(N_PE - 1))
                     state <= ST_RUN;
                  else
                     load_cnt <= load_cnt + IDX_W'(1);
               end
            end
            ST_RUN: begin
               if (in_valid) begin
                  if (last_tap) begin
                     done      <= 1'b1;
                     drain_idx <= '0;
                     state     <= HAS_DRAIN ? ST_DRAIN : ST_IDLE;
                  end else begin
                     tap_cnt <= tap_cnt + TAP_W'(1);
                  end
               end
            end
            ST_DRAIN: begin
               if (drain_idx == IDX_W'(N_PE - 1))
                  state <= ST_IDLE;
               else
                  drain_idx <= drain_idx + IDX_W'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/osa_rdmux.sv
// Selects one accumulator from the flattened result bus.
module osa_rdmux #(
   parameter int N_PE  = 8,
   parameter int ACC_W = 20,
   localparam int IDX_W = $clog2(N_PE)
) (
   input  logic [N_PE*ACC_W-1:0] flat,
   input  logic [IDX_W-1:0]      idx,
   output logic [ACC_W-1:0]      data
);
   always_comb data = flat[idx*ACC_W +: ACC_W];
endmodule

// File: rtl/osa_array.sv
module osa_array #(
   parameter int N_PE        = 8,
   parameter int DATA_W      = 8,
   parameter int ACC_W       = 20,
   parameter int MAX_TAPS    = 64,
   parameter bit SERIAL_READ = 1'b1,
   localparam int TAP_W      = $clog2(MAX_TAPS + 1),
   localparam int IDX_W      = $clog2(N_PE)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [TAP_W-1:0]         taps,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_wt,
   input  logic signed [DATA_W-1:0] in_act,
   output logic                     busy,
   output logic                     done,
   output logic [N_PE*ACC_W-1:0]    res_flat,
   output logic                     rd_valid,
   output logic [IDX_W-1:0]         rd_idx,
   output logic [ACC_W-1:0]         rd_data
);
   if (N_PE < 2) begin : g_bad_npe
      $error("osa_array: N_PE must be at least 2");
   end
   if (ACC_W < 2 * DATA_W) begin : g_bad_accw
      $error("osa_array: ACC_W must hold a full product");
   end
   if (MAX_TAPS < 1) begin : g_bad_taps
      $error("osa_array: MAX_TAPS must be positive");
   end

   logic clr, shift, mac_en, drain_valid;
   logic [IDX_W-1:0] drain_idx;
   logic signed [DATA_W-1:0] act_chain [N_PE];
   logic signed [ACC_W-1:0]  acc      [N_PE];

   osa_ctrl #(
      .N_PE      (N_PE),
      .MAX_TAPS  (MAX_TAPS),
      .HAS_DRAIN (SERIAL_READ)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .taps        (taps),
      .in_valid    (in_valid),
      .busy        (busy),
      .clr         (clr),
      .shift       (shift),
      .mac_en      (mac_en),
      .done        (done),
      .drain_valid (drain_valid),
      .drain_idx   (drain_idx)
   );

   for (genvar i = 0; i < N_PE; i++) begin : g_pe
      logic signed [DATA_W-1:0] feed;
      if (i == N_PE - 1) begin : g_top
         assign feed = in_act;
      end else begin : g_link
         assign feed = act_chain[i+1];
      end

      osa_pe #(
         .DATA_W (DATA_W),
         .ACC_W  (ACC_W)
      ) u_pe (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr),
         .shift  (shift),
         .mac_en (mac_en),
         .wt     (in_wt),
         .act_in (feed),
         .act_q  (act_chain[i]),
         .acc_q  (acc[i])
      );

      assign res_flat[i*ACC_W +: ACC_W] = acc[i];
   end

   if (SERIAL_READ) begin : g_serial
      osa_rdmux #(
         .N_PE  (N_PE),
         .ACC_W (ACC_W)
      ) u_rdmux (
         .flat (res_flat),
         .idx  (drain_idx),
         .data (rd_data)
      );
      assign rd_valid = drain_valid;
      assign rd_idx   = drain_idx;
   end else begin : g_parallel
      assign rd_valid = 1'b0;
      assign rd_idx   = '0;
      assign rd_data  = '0;
   end
endmodule

// File: rtl/osa_array_chk.sv
module osa_array_chk #(
   parameter int N_PE        = 8,
   parameter int ACC_W       = 20,
   parameter int TAP_W       = 7,
   parameter int IDX_W       = 3,
   parameter bit SERIAL_READ = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start,
   input logic [TAP_W-1:0]      taps,
   input logic                  busy,
   input logic                  done,
   input logic [N_PE*ACC_W-1:0] res_flat,
   input logic                  rd_valid,
   input logic [IDX_W-1:0]      rd_idx
);
   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && taps != '0) |=> busy);

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   assert_zero_taps_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && taps == '0) |=> !busy);

   assert_drain_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(rd_valid)) |-> (rd_idx == IDX_W'($past(rd_idx) + 1'b1)));

   assert_drain_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> busy);

   assert_done_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && SERIAL_READ) |-> (rd_valid && rd_idx == '0));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> $stable(res_flat));
endmodule

bind osa_array osa_array_chk #(
   .N_PE        (N_PE),
   .ACC_W       (ACC_W),
   .TAP_W       (TAP_W),
   .IDX_W       (IDX_W),
   .SERIAL_READ (SERIAL_READ)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .taps     (taps),
   .busy     (busy),
   .done     (done),
   .res_flat (res_flat),
   .rd_valid (rd_valid),
   .rd_idx   (rd_idx)
);

// File: tb/osa_array_tb.sv
`timescale 1ns/1ps
module osa_array_tb;
   localparam int NPE = 8;
   localparam int AW  = 20;
   localparam int MT  = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [6:0]       taps = '0;
   logic             in_valid = 1'b0;
   logic signed [7:0] in_wt = '0;
   logic signed [7:0] in_act = '0;
   logic             busy, done, rd_valid;
   logic [NPE*AW-1:0] res_flat;
   logic [2:0]       rd_idx;
   logic [AW-1:0]    rd_data;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   string cur_req = "R4";
   int exp_q[$];
   int last_res[NPE];
   int rd_seen = 0;
   int w_arr[MT];
   int x_arr[MT+NPE];

   always #2.5 clk = ~clk;

   osa_array u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .taps(taps),
      .in_valid(in_valid), .in_wt(in_wt), .in_act(in_act),
      .busy(busy), .done(done), .res_flat(res_flat),
      .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data)
   );

   function automatic int wrap20(int v);
      int r;
      r = v & 32'h000F_FFFF;
      if ((r & 32'h0008_0000) != 0) r = r - 32'h0010_0000;
      return r;
   endfunction

   function automatic int field(int i);
      logic signed [AW-1:0] f;
      f = res_flat[i*AW +: AW];
      return int'(f);
   endfunction

   task automatic check(string req, string what, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   // Monitor: compares the parallel bus at done and pops serial beats.
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            for (int i = 0; i < NPE; i++) begin
               check({cur_req, "/R6"}, $sformatf("parallel sum %0d at done", i),
                     field(i), (exp_q.size() > i) ? exp_q[i] : 32'h7FFF_FFFF);
               last_res[i] = (exp_q.size() > i) ? exp_q[i] : 0;
            end
         end
         if (rd_valid) begin
            check("R10", "serial index", int'(rd_idx), rd_seen % NPE);
            if (exp_q.size() > 0) begin
               logic signed [AW-1:0] d;
               d = rd_data;
               check({cur_req, "/R10"}, $sformatf("serial sum %0d", rd_seen % NPE),
                     int'(d), exp_q.pop_front());
            end else begin
               check("R10", "unexpected serial beat", 1, 0);
            end
            rd_seen++;
         end
      end
   end

   // Driver: computes the reference, queues it, then streams the job.
   task automatic run_conv(int s, int gap, bit poke_start);
      for (int i = 0; i < NPE; i++) begin
         int acc = 0;
         for (int k = 0; k < s; k++) acc += w_arr[k] * x_arr[i+k];
         exp_q.push_back(wrap20(acc));
      end
      rd_seen = 0;
      @(posedge clk); #1;
      start = 1'b1; taps = 7'(s);
      @(posedge clk); #1;
      start = 1'b0; taps = 7'(s == 1 ? 2 : 1);
      for (int b = 0; b < NPE + s; b++) begin
         in_valid = 1'b1;
         in_act   = 8'(x_arr[b]);
         in_wt    = (b >= NPE) ? 8'(w_arr[b-NPE]) : 8'(77);
         if (poke_start && b == NPE + 1) start = 1'b1;
         @(posedge clk); #1;
         start = 1'b0;
         for (int g = 0; g < gap; g++) begin
            in_valid = 1'b0; in_act = 8'(-99); in_wt = 8'(55);
            @(posedge clk); #1;
         end
      end
      in_valid = 1'b0;
      while (busy) begin
         @(posedge clk); #1;
      end
      @(negedge clk);
      check("R10", "queue drained after job", exp_q.size(), 0);
      check("R10", "serial beats per job", rd_seen, NPE);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R1", "busy after reset", int'(busy), 0);
      check("R1", "done after reset", int'(done), 0);
      check("R1", "rd_valid after reset", int'(rd_valid), 0);
      for (int i = 0; i < NPE; i++) check("R1", "sum after reset", field(i), 0);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R3 R4: ramp activations, three taps, back-to-back beats
      cur_req = "R3/R4";
      for (int j = 0; j < MT + NPE; j++) x_arr[j] = j + 1;
      w_arr[0] = 2; w_arr[1] = -3; w_arr[2] = 5;
      run_conv(3, 0, 1'b0);
      @(negedge clk);
      check("R2", "busy low after job", int'(busy), 0);

      // R5 R12: signed mixed data with idle gaps, fresh sums
      cur_req = "R5/R12";
      for (int j = 0; j < MT + NPE; j++) x_arr[j] = ((j * 37) % 256) - 128;
      for (int k = 0; k < 5; k++) w_arr[k] = ((k * 53 + 11) % 256) - 128;
      run_conv(5, 2, 1'b0);

      // Boundary: one tap
      cur_req = "R4";
      w_arr[0] = -7;
      run_conv(1, 0, 1'b0);

      // R8: start pulse during the compute phase
      cur_req = "R8";
      for (int k = 0; k < 6; k++) w_arr[k] = k - 3;
      run_conv(6, 1, 1'b1);

      // R9: zero taps start is ignored
      @(posedge clk); #1;
      start = 1'b1; taps = '0;
      @(posedge clk); #1;
      start = 1'b0;
      @(negedge clk);
      check("R9", "busy after zero-tap start", int'(busy), 0);
      for (int i = 0; i < NPE; i++) check("R9", "sum after zero-tap start", field(i), last_res[i]);

      // R11: idle beats are ignored
      @(posedge clk); #1;
      in_valid = 1'b1; in_wt = 8'(100); in_act = 8'(100);
      repeat (3) @(posedge clk);
      #1 in_valid = 1'b0;
      @(negedge clk);
      check("R11", "busy after idle beats", int'(busy), 0);
      for (int i = 0; i < NPE; i++) check("R11", "sum after idle beats", field(i), last_res[i]);

      // R7: maximum tap count, positive overflow wraps
      cur_req = "R7";
      for (int j = 0; j < MT + NPE; j++) x_arr[j] = 127;
      for (int k = 0; k < MT; k++) w_arr[k] = 127;
      run_conv(MT, 0, 1'b0);

      // R7: negative accumulation wrap with alternating signs
      for (int j = 0; j < MT + NPE; j++) x_arr[j] = (j % 2 == 0) ? -128 : 127;
      for (int k = 0; k < 40; k++) w_arr[k] = (k % 2 == 0) ? 127 : -128;
      run_conv(40, 0, 1'b0);

      repeat (3) @(posedge clk);
      summary();
   end
endmodule